// File: doc/BRIEF.md
# Interrupt Priority Router Core

This block gathers level-sensitive interrupt requests from a set of sources and routes each one to a small number of hart contexts. Software programs a priority for each source, an enable bit for each source in each context, and a threshold for each context. Each context has one interrupt output. That output stays high while at least one source is pending, enabled for that context and above the context's threshold.

A handler services interrupts through a claim/complete register in each context. A read of that register returns the ID of the winning source and takes that source out of arbitration. The source stays out until the handler writes the same ID back to the same context's register. The source then accepts a new request. ID 0 is reserved and is never a real source. A claim that returns 0 means that nothing is eligible.

All accesses use a simple 32-bit register port with byte addresses and word alignment. Read data appears one cycle after the read strobe. The reset input is asynchronous, active low, and is released to the core through a two-stage synchroniser.

Top module: `plic_core`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, every claim read returns 0, and every context output is low.
- R2: The priority of source N (1..NUM_SRC) lives at byte address 4×N. Its low PRIO_W bits are stored, and the upper bits read as 0.
- R3: The enable vector of context C starts at byte 0x2000 + 0x80×C. Source N is bit (N mod 32) of word N/32. Bit 0 of word 0 always reads 0, and a source enabled only in another context never drives C's output.
- R4: The threshold of context C is at byte 0x200000 + 0x1000×C and keeps PRIO_W bits. The claim/complete register of C is 4 bytes above it.
- R5: Context output C is high exactly when some source is pending, enabled for C and has a priority strictly greater than C's threshold.
- R6: A source with priority 0 never raises a context output and is never returned by a claim, whatever the threshold.
- R7: A claim read returns the eligible source with the highest priority. On a tie the lowest ID wins. With no eligible source the read returns 0. The value appears on reg_rdata in the cycle after the read strobe.
- R8: A claim clears the source's pending state at the claim edge, so a context output with no other eligible source is low in the next cycle. While the source is claimed, a request that stays high does not make it pending again.
- R9: A completion write of the claimed ID to the context that claimed it releases the source. A request that is still high makes the source pending at the second clock edge after the write.
- R10: A completion write is ignored if the ID is not held by that context, including IDs held by another context, ID 0 and out-of-range IDs.
- R11: Writes to the priority of source 0, to misaligned addresses and to unmapped addresses change nothing. Reads of those addresses return 0.
- R12: A request that is high for even one cycle stays pending until it is claimed, even after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Level requests; bit k is source k+1 |
| reg_addr | input | 32 | Byte address of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe; claim reads take effect at this edge |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| ctx_irq | output | NUM_CTX | Interrupt output per context |

## Verification
The timing of each result is fixed. Read data arrives one edge after the strobe. Configuration writes and claim side effects change the context outputs directly after the edge that takes them. A request becomes pending at the first edge, and a released source that is still requesting becomes pending again at the second edge after the completion write. The bench drives every access on a falling edge and samples on the next falling edge, so each output is read in the first cycle it becomes due. For R8 and R9 the bench also samples the cycle before the output is due, to show the output has not yet changed. Source priorities, thresholds and claim order are swept over every source and every priority/threshold pair, with the winner worked out arithmetically from the programmed values.

// File: rtl/plic_pkg.sv
package plic_pkg;

  // Fixed address map anchors (byte addresses)
  localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTL_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;
  localparam logic [11:0] THR_OFF    = 12'h000;
  localparam logic [11:0] CLAIM_OFF  = 12'h004;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_PRIO,
    KIND_EN,
    KIND_THR,
    KIND_CLAIM
  } reg_kind_e;

endpackage

// File: rtl/plic_decode.sv
module plic_decode
  import plic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned ID_W    = 5,
  parameter int unsigned CTX_W   = 1,
  parameter int unsigned WORD_W  = 1
) (
  input  logic [31:0]       addr,
  output reg_kind_e         kind,
  output logic [ID_W-1:0]   src_id,
  output logic [CTX_W-1:0]  ctx,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam logic [31:0] PRIO_END  = 32'(4 * (NUM_SRC + 1));
  localparam logic [31:0] EN_SPAN   = 32'(NUM_CTX) * EN_STRIDE;
  localparam logic [31:0] CTL_SPAN  = 32'(NUM_CTX) * CTL_STRIDE;

  logic [31:0] en_off;
  logic [31:0] ctl_off;

  always_comb begin
    en_off  = addr - EN_BASE;
    ctl_off = addr - CTL_BASE;
    kind    = KIND_NONE;
    src_id  = '0;
    ctx     = '0;
    word    = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr > PRIO_BASE && addr < PRIO_END) begin
        kind   = KIND_PRIO;
        src_id = addr[2 +: ID_W];
      end else if (addr >= EN_BASE && en_off < EN_SPAN &&
                   {27'd0, en_off[6:2]} < 32'(NUM_WORDS)) begin
        kind = KIND_EN;
        ctx  = en_off[7 +: CTX_W];
        word = en_off[2 +: WORD_W];
      end else if (addr >= CTL_BASE && ctl_off < CTL_SPAN) begin
        ctx = ctl_off[12 +: CTX_W];
        if (ctl_off[11:0] == THR_OFF) begin
          kind = KIND_THR;
        end else if (ctl_off[11:0] == CLAIM_OFF) begin
          kind = KIND_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter int unsigned NUM_CTX = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [NUM_CTX-1:0] take,
  input  logic [NUM_CTX-1:0] done,
  output logic               pend,
  output logic [NUM_CTX-1:0] own
);

  logic               pend_q, pend_n;
  logic [NUM_CTX-1:0] own_q, own_n;
  logic               busy;

  always_comb begin
    busy  = |own_q;
    own_n = (own_q & ~done) | take;
    if (|take) begin
      pend_n = 1'b0;
    end else begin
      pend_n = pend_q | (req & ~busy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      own_q  <= '0;
    end else begin
      pend_q <= pend_n;
      own_q  <= own_n;
    end
  end

  assign pend = pend_q;
  assign own  = own_q;

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           best
);

  logic [PRIO_W-1:0] bar;

  // Ascending scan with a strict compare: the bar starts at the threshold,
  // and equal priorities never displace an earlier (lower) ID.
  always_comb begin
    bar  = thr;
    best = '0;
    for (int s = 0; s < int'(NUM_SRC); s++) begin
      if (pend[s] && en[s] && prio[s*PRIO_W +: PRIO_W] > bar) begin
        bar  = prio[s*PRIO_W +: PRIO_W];
        best = ID_W'(s + 1);
      end
    end
  end

endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [31:0]        reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_re,
  output logic [31:0]        reg_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);

  localparam int unsigned ID_W      = $clog2(NUM_SRC + 1);
  localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int unsigned NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  // Reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // Address decode
  reg_kind_e         dec_kind;
  logic [ID_W-1:0]   dec_id;
  logic [CTX_W-1:0]  dec_ctx;
  logic [WORD_W-1:0] dec_word;

  plic_decode #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .ID_W(ID_W), .CTX_W(CTX_W), .WORD_W(WORD_W)
  ) u_dec (
    .addr  (reg_addr),
    .kind  (dec_kind),
    .src_id(dec_id),
    .ctx   (dec_ctx),
    .word  (dec_word)
  );

  // Configuration state
  logic [NUM_SRC*PRIO_W-1:0]  prio_q, prio_n;
  logic [NUM_CTX*NUM_SRC-1:0] en_q,   en_n;
  logic [NUM_CTX*PRIO_W-1:0]  thr_q,  thr_n;
  logic                       cfg_we;

  // Runtime state views
  logic [NUM_SRC-1:0]         pend_w;
  logic [NUM_CTX*NUM_SRC-1:0] own_w;
  logic [NUM_CTX*ID_W-1:0]    best_w;
  logic [NUM_CTX-1:0]         claim_fire;
  logic [NUM_CTX-1:0]         done_fire;

  logic [31:0] rdata_q, rdata_n;

  assign cfg_we = reg_we && (dec_kind == KIND_PRIO || dec_kind == KIND_EN ||
                             dec_kind == KIND_THR);

  always_comb begin
    prio_n = prio_q;
    en_n   = en_q;
    thr_n  = thr_q;
    case (dec_kind)
      KIND_PRIO: begin
        for (int s = 1; s <= int'(NUM_SRC); s++) begin
          if (dec_id == ID_W'(s)) begin
            prio_n[(s-1)*PRIO_W +: PRIO_W] = reg_wdata[PRIO_W-1:0];
          end
        end
      end
      KIND_EN: begin
        for (int c = 0; c < int'(NUM_CTX); c++) begin
          for (int s = 1; s <= int'(NUM_SRC); s++) begin
            if (dec_ctx == CTX_W'(c) && dec_word == WORD_W'(s / 32)) begin
              en_n[c*NUM_SRC + s - 1] = reg_wdata[s % 32];
            end
          end
        end
      end
      KIND_THR: begin
        for (int c = 0; c < int'(NUM_CTX); c++) begin
          if (dec_ctx == CTX_W'(c)) begin
            thr_n[c*PRIO_W +: PRIO_W] = reg_wdata[PRIO_W-1:0];
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      prio_q <= prio_n;
      en_q   <= en_n;
      thr_q  <= thr_n;
    end
  end

  // Read data path
  always_comb begin
    rdata_n = '0;
    case (dec_kind)
      KIND_PRIO: begin
        for (int s = 1; s <= int'(NUM_SRC); s++) begin
          if (dec_id == ID_W'(s)) begin
            rdata_n[PRIO_W-1:0] = prio_q[(s-1)*PRIO_W +: PRIO_W];
          end
        end
      end
      KIND_EN: begin
        for (int c = 0; c < int'(NUM_CTX); c++) begin
          for (int s = 1; s <= int'(NUM_SRC); s++) begin
            if (dec_ctx == CTX_W'(c) && dec_word == WORD_W'(s / 32)) begin
              rdata_n[s % 32] = en_q[c*NUM_SRC + s - 1];
            end
          end
        end
      end
      KIND_THR: begin
        for (int c = 0; c < int'(NUM_CTX); c++) begin
          if (dec_ctx == CTX_W'(c)) begin
            rdata_n[PRIO_W-1:0] = thr_q[c*PRIO_W +: PRIO_W];
          end
        end
      end
      KIND_CLAIM: begin
        for (int c = 0; c < int'(NUM_CTX); c++) begin
          if (dec_ctx == CTX_W'(c)) begin
            rdata_n[ID_W-1:0] = best_w[c*ID_W +: ID_W];
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      rdata_q <= rdata_n;
    end
  end

  assign reg_rdata = rdata_q;

  // Claim / complete strobes per context
  always_comb begin
    for (int c = 0; c < int'(NUM_CTX); c++) begin
      claim_fire[c] = reg_re && dec_kind == KIND_CLAIM && dec_ctx == CTX_W'(c);
      done_fire[c]  = reg_we && dec_kind == KIND_CLAIM && dec_ctx == CTX_W'(c);
    end
  end

  // One gateway per source
  genvar gs, gc;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      logic [NUM_CTX-1:0] take;
      logic [NUM_CTX-1:0] done;
      logic [NUM_CTX-1:0] own;

      for (gc = 0; gc < NUM_CTX; gc++) begin : g_ctx
        assign take[gc] = claim_fire[gc] &&
                          best_w[gc*ID_W +: ID_W] == ID_W'(gs + 1);
        assign done[gc] = done_fire[gc] && reg_wdata == 32'(gs + 1);
        assign own_w[gc*NUM_SRC + gs] = own[gc];
      end

      plic_gateway #(.NUM_CTX(NUM_CTX)) u_gw (
        .clk  (clk),
        .rst_n(rst_core_n),
        .req  (src_req[gs]),
        .take (take),
        .done (done),
        .pend (pend_w[gs]),
        .own  (own)
      );
    end

    // One arbiter per context
    for (gc = 0; gc < NUM_CTX; gc++) begin : g_arb
      plic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .pend(pend_w),
        .en  (en_q[gc*NUM_SRC +: NUM_SRC]),
        .prio(prio_q),
        .thr (thr_q[gc*PRIO_W +: PRIO_W]),
        .best(best_w[gc*ID_W +: ID_W])
      );
      assign ctx_irq[gc] = |best_w[gc*ID_W +: ID_W];
    end
  endgenerate

endmodule

// File: rtl/plic_core_checker.sv
module plic_core_checker #(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CTX-1:0]         ctx_irq,
  input logic [NUM_SRC-1:0]         pend_w,
  input logic [NUM_CTX*NUM_SRC-1:0] own_w,
  input logic [NUM_CTX*NUM_SRC-1:0] en_q,
  input logic [NUM_SRC*PRIO_W-1:0]  prio_q,
  input logic [NUM_CTX*PRIO_W-1:0]  thr_q,
  input logic [NUM_CTX*$clog2(NUM_SRC+1)-1:0] best_w,
  input logic [NUM_CTX-1:0]         claim_fire
);

  localparam int unsigned ID_W = $clog2(NUM_SRC + 1);

  logic [NUM_CTX-1:0][NUM_SRC-1:0] win_mask;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  win_prio;
  logic [NUM_SRC-1:0][NUM_CTX-1:0] owners;

  always_comb begin
    for (int c = 0; c < int'(NUM_CTX); c++) begin
      win_mask[c] = '0;
      win_prio[c] = '0;
      for (int s = 0; s < int'(NUM_SRC); s++) begin
        if (best_w[c*ID_W +: ID_W] == ID_W'(s + 1)) begin
          win_mask[c][s] = 1'b1;
          win_prio[c]    = prio_q[s*PRIO_W +: PRIO_W];
        end
        owners[s][c] = own_w[c*NUM_SRC + s];
      end
    end
  end

  genvar gc, gs;
  generate
    for (gc = 0; gc < NUM_CTX; gc++) begin : g_ctx_chk
      // R5: an asserted output is backed by a pending, enabled source
      a_r5_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_irq[gc] |-> |(pend_w & en_q[gc*NUM_SRC +: NUM_SRC]));

      // R6: the winner's priority clears the threshold, so priority 0 never wins
      a_r6_winner_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (|win_mask[gc]) |-> (win_prio[gc] > thr_q[gc*PRIO_W +: PRIO_W]));

      // R8: a claimed source is no longer pending after the claim edge
      a_r8_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_fire[gc] && |win_mask[gc]) |=> ((pend_w & $past(win_mask[gc])) == '0));
    end

    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src_chk
      // R10: a source is held by at most one context at a time
      a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owners[gs]));

      // R8: a held source cannot be pending at the same time
      a_r8_held_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_w[gs] && |owners[gs]));
    end
  endgenerate

endmodule

bind plic_core plic_core_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctx_irq   (ctx_irq),
  .pend_w    (pend_w),
  .own_w     (own_w),
  .en_q      (en_q),
  .prio_q    (prio_q),
  .thr_q     (thr_q),
  .best_w    (best_w),
  .claim_fire(claim_fire)
);

// File: tb/tb_plic_core.sv
`timescale 1ns/1ps
module tb_plic_core;

  localparam int NS = 31;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_req;
  logic [31:0]   reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata;
  logic          reg_re;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] ctx_irq;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  plic_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .ctx_irq(ctx_irq)
  );

  function automatic logic [31:0] a_prio(int s);  return 32'(4 * s); endfunction
  function automatic logic [31:0] a_en(int c);    return 32'h2000 + 32'(c * 128); endfunction
  function automatic logic [31:0] a_thr(int c);   return 32'h20_0000 + 32'(c * 4096); endfunction
  function automatic logic [31:0] a_claim(int c); return a_thr(c) + 32'd4; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_req = '0; reg_we = 1'b0; reg_re = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pr [NS+1];
    bit rem [NS+1];
    int exp_id, bp;

    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1 irq", 32'(ctx_irq), 0);
    rd(a_prio(1), d);   chk("R1 prio1", d, 0);
    rd(a_prio(NS), d);  chk("R1 prio31", d, 0);
    rd(a_en(1), d);     chk("R1 en1", d, 0);
    rd(a_thr(0), d);    chk("R1 thr0", d, 0);
    rd(a_claim(0), d);  chk("R1 claim0", d, 0);
    rd(a_claim(1), d);  chk("R1 claim1", d, 0);

    // R2: priority registers, only PRIO_W bits kept
    for (int s = 1; s <= NS; s++) wr(a_prio(s), 32'hABCD_0000 | 32'(s));
    for (int s = 1; s <= NS; s++) begin
      rd(a_prio(s), d);
      chk($sformatf("R2 prio src%0d", s), d, 32'(s % 8));
    end

    // R11: source 0, misaligned and unmapped addresses
    wr(32'h0, 32'h7);          rd(32'h0, d);          chk("R11 prio src0", d, 0);
    wr(32'h5, 32'h7);          rd(a_prio(1), d);      chk("R11 misaligned write", d, 1);
    rd(32'h5, d);              chk("R11 misaligned read", d, 0);
    wr(32'h1000, 32'h7);       rd(32'h1000, d);       chk("R11 gap read", d, 0);
    wr(a_en(2), 32'hFFFF_FFFF); rd(a_en(2), d);       chk("R11 en ctx2", d, 0);
    wr(a_thr(2), 32'h7);       rd(a_thr(2), d);       chk("R11 thr ctx2", d, 0);
    wr(a_thr(0) + 8, 32'h7);   rd(a_thr(0) + 8, d);   chk("R11 ctl gap", d, 0);
    rd(a_thr(0), d);           chk("R11 thr0 untouched", d, 0);

    // R3 / R4: enable and threshold registers
    wr(a_en(0), 32'hFFFF_FFFF);  rd(a_en(0), d); chk("R3 en0", d, 32'hFFFF_FFFE);
    wr(a_en(1), 32'hA5A5_A5A5);  rd(a_en(1), d); chk("R3 en1", d, 32'hA5A5_A5A4);
    rd(a_en(0), d);              chk("R3 en0 kept", d, 32'hFFFF_FFFE);
    wr(a_thr(1), 32'hFF);        rd(a_thr(1), d); chk("R4 thr1", d, 7);
    rd(a_thr(0), d);             chk("R4 thr0 kept", d, 0);

    // R5/R6/R8/R9: per-source sweep of every priority/threshold pair
    for (int s = 1; s <= NS; s++) begin
      do_reset();
      wr(a_en(0), 32'(1) << s);
      src_req[s-1] = 1'b1;
      for (int p = 0; p < 8; p++) begin
        wr(a_prio(s), 32'(p));
        for (int t = 0; t < 8; t++) begin
          wr(a_thr(0), 32'(t));
          chk($sformatf("R5 R6 src%0d p%0d t%0d irq0", s, p, t),
              32'(ctx_irq[0]), 32'(p > t));
          chk($sformatf("R3 src%0d irq1", s), 32'(ctx_irq[1]), 0);
        end
      end
      wr(a_thr(0), 32'd0);
      wr(a_prio(s), 32'd7);
      rd(a_claim(0), d);
      chk($sformatf("R7 src%0d claim", s), d, 32'(s));
      chk($sformatf("R8 src%0d irq falls", s), 32'(ctx_irq[0]), 0);
      repeat (3) @(negedge clk);
      chk($sformatf("R8 src%0d held", s), 32'(ctx_irq[0]), 0);
      wr(a_claim(0), 32'(s));
      chk($sformatf("R9 src%0d not yet", s), 32'(ctx_irq[0]), 0);
      @(negedge clk);
      chk($sformatf("R9 src%0d re-pend", s), 32'(ctx_irq[0]), 1);
    end

    // R7/R12: arbitration order with one-cycle request pulses
    for (int k = 0; k < 3; k++) begin
      do_reset();
      for (int s = 1; s <= NS; s++) begin
        pr[s] = (s * 5 + k * 3) % 8;
        wr(a_prio(s), 32'(pr[s]));
        rem[s] = (pr[s] > k);
      end
      wr(a_en(0), 32'hFFFF_FFFE);
      wr(a_thr(0), 32'(k));
      src_req = '1;
      @(negedge clk);
      src_req = '0;
      repeat (2) @(negedge clk);
      for (int n = 0; n <= NS; n++) begin
        exp_id = 0; bp = k;
        for (int s = 1; s <= NS; s++) begin
          if (rem[s] && pr[s] > bp) begin bp = pr[s]; exp_id = s; end
        end
        rd(a_claim(0), d);
        chk($sformatf("R7 R12 round%0d step%0d", k, n), d, 32'(exp_id));
        if (exp_id == 0) break;
        rem[exp_id] = 0;
      end
      chk($sformatf("R7 round%0d irq idle", k), 32'(ctx_irq), 0);
      for (int s = 1; s <= NS; s++) wr(a_claim(0), 32'(s));
      repeat (2) @(negedge clk);
      chk($sformatf("R12 round%0d no re-pend", k), 32'(ctx_irq), 0);
    end

    // R10: completions that must be ignored
    do_reset();
    wr(a_prio(3), 32'd5);
    wr(a_en(0), 32'h8);
    wr(a_en(1), 32'h8);
    src_req[2] = 1'b1;
    @(negedge clk);
    chk("R5 both ctx", 32'(ctx_irq), 32'h3);
    rd(a_claim(1), d);   chk("R10 claim ctx1", d, 3);
    chk("R8 both fall", 32'(ctx_irq), 0);
    wr(a_claim(0), 32'd3);
    repeat (3) @(negedge clk);
    chk("R10 wrong ctx", 32'(ctx_irq), 0);
    wr(a_claim(1), 32'd0);
    wr(a_claim(1), 32'd40);
    wr(a_claim(1), 32'h1_0003);
    repeat (3) @(negedge clk);
    chk("R10 bad ids", 32'(ctx_irq), 0);
    rd(a_claim(0), d);   chk("R10 ctx0 empty", d, 0);
    wr(a_claim(1), 32'd3);
    @(negedge clk);
    chk("R9 right ctx", 32'(ctx_irq), 32'h3);
    rd(a_claim(0), d);   chk("R9 reclaim ctx0", d, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule